// File: doc/BRIEF.md
# Cross-Pipe Frame Lock Trigger

This block lets one display timing generator lock onto the frame timing of another pipe. It watches the vertical sync of a pipe chosen by an index. It brings that sync into the local clock domain, picks out the edge that marks the start of sync, and, when armed, pulses a force-load strobe. Along with the strobe it outputs the local horizontal and vertical totals as the load values. The local counters take those values, sit on the last position of the frame, and wrap to the first pixel of a new frame one pixel later.

A sticky status flag records that a forced load has happened, so control logic can confirm that the lock took place. By default only the first edge after the flag was cleared forces a load. A re-arm mode lets every edge force one. The block does not generate any timing itself.

Top module: `frame_lock_trigger`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `force_load` and `lock_seen` are 0.
- R2: Only the vsync of the pipe selected by `src_sel` (bit index into `pipe_vsync`) can cause a forced load. Edges on other pipes have no effect.
- R3: When `vs_active_low` is 1 only a falling edge of the selected vsync triggers. When it is 0 only a rising edge triggers. The opposite edge is ignored.
- R4: A triggering edge gives a one-cycle `force_load` pulse 3 clock edges after the input changes (2 synchroniser flops, then the registered strobe). During that pulse `force_hcount` equals `h_total` and `force_vcount` equals `v_total`.
- R5: `lock_seen` becomes 1 in the same cycle as `force_load` and stays 1 until it is cleared.
- R6: A one-cycle `clr_seen` pulse clears `lock_seen` at the next edge. If a trigger fires in the same cycle, the flag stays set.
- R7: While `arm` is 0, edges neither pulse `force_load` nor set `lock_seen`.
- R8: When `rearm` is 0, edges are ignored while `lock_seen` is 1. After a clear, the next edge forces a load again.
- R9: When `rearm` is 1, every triggering edge forces a load, even while `lock_seen` is 1.
- R10: Only `force_mode` code 2 (load totals) forces a load. Codes 0, 1 and 3 never pulse `force_load` or set `lock_seen`.
- R11: In the cycle in which the synchronised selection differs from the previous cycle's selection, no edge is detected. Switching to a pipe whose level differs from the old pipe's level does not trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local pixel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_vsync | input | NUM_PIPES | Vsync of every pipe, asynchronous to `clk` |
| src_sel | input | SEL_W | Index of the source pipe |
| vs_active_low | input | 1 | 1: sync asserts low, so falling edge triggers |
| arm | input | 1 | Enables edge detection |
| rearm | input | 1 | 1: every edge forces; 0: single shot |
| force_mode | input | 2 | Force mode code; 2 loads the totals |
| clr_seen | input | 1 | Clears the sticky flag |
| h_total | input | H_W | Last horizontal count position |
| v_total | input | V_W | Last vertical count position |
| force_load | output | 1 | One-cycle strobe to load the counters |
| force_hcount | output | H_W | Horizontal load value |
| force_vcount | output | V_W | Vertical load value |
| lock_seen | output | 1 | Sticky flag: a forced load occurred |

## Verification
The trigger is driven with rising and falling edges on the selected pipe under both polarity settings. This separates correct edge choice from detection of any transition. Toggles on pipes that are not selected, edges while disarmed and edges under the other mode codes must give no strobe, which tells gating faults apart from detection faults. Repeated edges with and without re-arm, a clear that collides with a trigger, and a source switch between pipes at different levels test the sticky and single-shot logic and the false edge at a switch. The scoreboard predicts the exact strobe cycle and load values for each edge, so a wrong latency or a stale total is caught as well as a missing strobe.

// File: rtl/vlock_pkg.sv
package vlock_pkg;

  typedef enum logic [1:0] {
    FM_NONE   = 2'd0,
    FM_RSVD_A = 2'd1,
    FM_TOTALS = 2'd2,
    FM_RSVD_B = 2'd3
  } force_mode_e;

  // Edge of interest: start of sync for the given polarity.
  function automatic logic sync_start(input logic prev, input logic cur,
                                      input logic active_low);
    return active_low ? (prev & ~cur) : (~prev & cur);
  endfunction

endpackage

// File: rtl/vlock_sync.sv
module vlock_sync #(
  parameter int NUM_PIPES = 4,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PIPES-1:0] async_i,
  output logic [NUM_PIPES-1:0] sync_o
);

  localparam int LAST = STAGES - 1;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_i[p]};
    end
    assign sync_o[p] = chain[LAST];
  end

endmodule

// File: rtl/vlock_edge_sel.sv
module vlock_edge_sel
  import vlock_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int SEL_W     = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PIPES-1:0] sync_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 active_low_i,
  output logic                 edge_o
);

  localparam logic [SEL_W:0] NP = (SEL_W+1)'(NUM_PIPES);

  logic             cur;
  logic             prev_q;
  logic [SEL_W-1:0] sel_q;
  logic             sel_moved;

  always_comb begin
    cur = 1'b0;
    if ({1'b0, sel_i} < NP) cur = sync_i[sel_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      prev_q <= cur;
      sel_q  <= sel_i;
    end
  end

  // History belongs to the old source in a switch cycle: hold off.
  assign sel_moved = (sel_q != sel_i);
  assign edge_o    = !sel_moved && sync_start(prev_q, cur, active_low_i);

  p_switch_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (sel_i != $past(sel_i)) |-> !edge_o);

endmodule

// File: rtl/vlock_force_ctl.sv
module vlock_force_ctl
  import vlock_pkg::*;
#(
  parameter int H_W = 14,
  parameter int V_W = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           edge_i,
  input  logic           arm_i,
  input  logic           rearm_i,
  input  logic [1:0]     mode_i,
  input  logic           clr_i,
  input  logic [H_W-1:0] h_total_i,
  input  logic [V_W-1:0] v_total_i,
  output logic           load_o,
  output logic [H_W-1:0] h_o,
  output logic [V_W-1:0] v_o,
  output logic           occurred_o
);

  logic mode_ok;
  logic open_gate;
  logic fire;

  assign mode_ok   = (force_mode_e'(mode_i) == FM_TOTALS);
  assign open_gate = !occurred_o || rearm_i;
  assign fire      = edge_i && arm_i && mode_ok && open_gate;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_o     <= 1'b0;
      h_o        <= '0;
      v_o        <= '0;
      occurred_o <= 1'b0;
    end else begin
      load_o <= fire;
      if (fire) begin
        h_o <= h_total_i;
        v_o <= v_total_i;
      end
      if (fire)       occurred_o <= 1'b1;
      else if (clr_i) occurred_o <= 1'b0;
    end
  end

  p_strobe_flag_r5: assert property (@(posedge clk) disable iff (rst)
    load_o |-> occurred_o);
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (occurred_o && !clr_i) |=> occurred_o);
  p_strobe_once_r4: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o);
  p_load_vals_r4: assert property (@(posedge clk) disable iff (rst)
    load_o |-> (h_o == $past(h_total_i) && v_o == $past(v_total_i)));
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !edge_i) |=> !occurred_o);
  p_disarmed_r7: assert property (@(posedge clk) disable iff (rst)
    load_o |-> $past(arm_i));
  p_single_shot_r8: assert property (@(posedge clk) disable iff (rst)
    (occurred_o && !rearm_i) |=> !load_o);
  p_mode_r10: assert property (@(posedge clk) disable iff (rst)
    load_o |-> ($past(mode_i) == 2'd2));

endmodule

// File: rtl/frame_lock_trigger.sv
module frame_lock_trigger #(
  parameter int NUM_PIPES = 4,
  parameter int H_W       = 14,
  parameter int V_W       = 14,
  parameter int SYNC_FF   = 2,
  parameter int SEL_W     = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PIPES-1:0] pipe_vsync,
  input  logic [SEL_W-1:0]     src_sel,
  input  logic                 vs_active_low,
  input  logic                 arm,
  input  logic                 rearm,
  input  logic [1:0]           force_mode,
  input  logic                 clr_seen,
  input  logic [H_W-1:0]       h_total,
  input  logic [V_W-1:0]       v_total,
  output logic                 force_load,
  output logic [H_W-1:0]       force_hcount,
  output logic [V_W-1:0]       force_vcount,
  output logic                 lock_seen
);

  logic [NUM_PIPES-1:0] vs_sync;
  logic                 start_edge;

  vlock_sync #(.NUM_PIPES(NUM_PIPES), .STAGES(SYNC_FF)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pipe_vsync),
    .sync_o  (vs_sync)
  );

  vlock_edge_sel #(.NUM_PIPES(NUM_PIPES), .SEL_W(SEL_W)) u_edge (
    .clk          (clk),
    .rst          (rst),
    .sync_i       (vs_sync),
    .sel_i        (src_sel),
    .active_low_i (vs_active_low),
    .edge_o       (start_edge)
  );

  vlock_force_ctl #(.H_W(H_W), .V_W(V_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .edge_i     (start_edge),
    .arm_i      (arm),
    .rearm_i    (rearm),
    .mode_i     (force_mode),
    .clr_i      (clr_seen),
    .h_total_i  (h_total),
    .v_total_i  (v_total),
    .load_o     (force_load),
    .h_o        (force_hcount),
    .v_o        (force_vcount),
    .occurred_o (lock_seen)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!force_load && !lock_seen));

endmodule

// File: tb/sim_frame_lock_trigger.sv
module sim_frame_lock_trigger;

  localparam int NP = 4;
  localparam int SW = 2;
  localparam int HW = 14;
  localparam int VW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pipe_vsync = '0;
  logic [SW-1:0] src_sel = '0;
  logic          vs_active_low = 1'b0;
  logic          arm = 1'b0;
  logic          rearm = 1'b0;
  logic [1:0]    force_mode = 2'd2;
  logic          clr_seen = 1'b0;
  logic [HW-1:0] h_total = '0;
  logic [VW-1:0] v_total = '0;
  logic          force_load;
  logic [HW-1:0] force_hcount;
  logic [VW-1:0] force_vcount;
  logic          lock_seen;

  always #4 clk = ~clk;

  frame_lock_trigger #(.NUM_PIPES(NP), .H_W(HW), .V_W(VW)) u0 (
    .clk(clk), .rst(rst), .pipe_vsync(pipe_vsync), .src_sel(src_sel),
    .vs_active_low(vs_active_low), .arm(arm), .rearm(rearm),
    .force_mode(force_mode), .clr_seen(clr_seen), .h_total(h_total),
    .v_total(v_total), .force_load(force_load), .force_hcount(force_hcount),
    .force_vcount(force_vcount), .lock_seen(lock_seen)
  );

  typedef struct {
    int    cyc;
    int    h;
    int    v;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: compare every strobe with the scoreboard head.
  always @(negedge clk) begin
    if (force_load) begin
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R2/R7/R8/R10/R11: got unexpected strobe at cycle %0d expected none", cyc);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.cyc != cyc || e.h != int'(force_hcount) || e.v != int'(force_vcount)) begin
          n_fail++;
          $display("FAIL %s: got cyc %0d h %0d v %0d expected cyc %0d h %0d v %0d",
                   e.req, cyc, force_hcount, force_vcount, e.cyc, e.h, e.v);
        end
      end
    end else if (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      n_fail++;
      $display("FAIL %s: got no strobe at cycle %0d expected strobe", e.req, e.cyc);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: change one vsync line, push the predicted strobe when due.
  task automatic drive_vs(int p, logic val, bit fire, string req);
    @(negedge clk);
    pipe_vsync[p] = val;
    if (fire) begin
      exp_t e;
      e.cyc = cyc + 3;
      e.h   = int'(h_total);
      e.v   = int'(v_total);
      e.req = req;
      q.push_back(e);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr_seen = 1'b1;
    @(negedge clk);
    clr_seen = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    tick(2);
    chk("R1 strobe in reset", force_load, 0);
    chk("R1 flag in reset", lock_seen, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 strobe after reset", force_load, 0);
    chk("R1 flag after reset", lock_seen, 0);

    src_sel = 2'd2; h_total = 14'd799; v_total = 14'd524;
    tick(4);

    // R7: disarmed edge ignored
    drive_vs(2, 1'b1, 0, "R7");
    tick(6);
    chk("R7 flag while disarmed", lock_seen, 0);
    arm = 1'b1;
    tick(3);

    // R3: falling edge ignored under rising polarity
    drive_vs(2, 1'b0, 0, "R3");
    tick(6);
    chk("R3 opposite edge", lock_seen, 0);

    // R2: other pipe ignored
    drive_vs(1, 1'b1, 0, "R2");
    drive_vs(1, 1'b0, 0, "R2");
    tick(6);
    chk("R2 unselected pipe", lock_seen, 0);

    // R4/R5: selected rising edge forces totals
    drive_vs(2, 1'b1, 1, "R4");
    tick(6);
    chk("R5 flag set", lock_seen, 1);

    // R8: single shot, later edge ignored
    drive_vs(2, 1'b0, 0, "R8");
    drive_vs(2, 1'b1, 0, "R8");
    tick(10);
    chk("R5 flag sticky", lock_seen, 1);

    // R6: clear
    pulse_clr();
    chk("R6 clear", lock_seen, 0);

    // R8: after clear next edge forces with new totals
    h_total = 14'd1099; v_total = 14'd1124;
    drive_vs(2, 1'b0, 0, "R8");
    drive_vs(2, 1'b1, 1, "R8");
    tick(6);
    chk("R8 re-fire after clear", lock_seen, 1);

    // R9: re-arm mode, every edge forces
    rearm = 1'b1;
    drive_vs(2, 1'b0, 0, "R9");
    drive_vs(2, 1'b1, 1, "R9");
    tick(5);
    drive_vs(2, 1'b0, 0, "R9");
    drive_vs(2, 1'b1, 1, "R9");
    tick(6);

    // R6: clear in the same cycle as a trigger
    drive_vs(2, 1'b0, 0, "R6");
    drive_vs(2, 1'b1, 1, "R6");
    @(negedge clk);
    @(negedge clk);
    clr_seen = 1'b1;
    @(negedge clk);
    clr_seen = 1'b0;
    chk("R6 trigger beats clear", lock_seen, 1);
    tick(3);
    pulse_clr();
    chk("R6 clear alone", lock_seen, 0);
    rearm = 1'b0;

    // R3: active-low polarity, falling edge triggers
    vs_active_low = 1'b1;
    tick(3);
    drive_vs(2, 1'b0, 1, "R3");
    tick(6);
    chk("R3 falling edge fires", lock_seen, 1);
    pulse_clr();
    drive_vs(2, 1'b1, 0, "R3");
    tick(6);
    chk("R3 rising ignored when active low", lock_seen, 0);

    // R10: other mode codes do not force
    force_mode = 2'd1;
    drive_vs(2, 1'b0, 0, "R10");
    tick(6);
    force_mode = 2'd3;
    drive_vs(2, 1'b1, 0, "R10");
    drive_vs(2, 1'b0, 0, "R10");
    tick(6);
    force_mode = 2'd0;
    drive_vs(2, 1'b1, 0, "R10");
    drive_vs(2, 1'b0, 0, "R10");
    tick(6);
    chk("R10 non-force modes", lock_seen, 0);
    force_mode = 2'd2;

    // R11: source switch between different levels does not trigger
    vs_active_low = 1'b0;
    drive_vs(3, 1'b1, 0, "R11");
    tick(6);
    @(negedge clk);
    src_sel = 2'd3;
    tick(8);
    chk("R11 switch no trigger", lock_seen, 0);
    drive_vs(3, 1'b0, 0, "R11");
    drive_vs(3, 1'b1, 1, "R11");
    tick(6);
    chk("R11 new source fires", lock_seen, 1);

    tick(4);
    chk("scoreboard drained", q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

endmodule